// File: doc/BRIEF.md
# MDIO Management Master with Programmable Clock Divider

This block carries out Clause 22 management transactions toward Ethernet PHYs. Software sees two 32-bit registers. The setup register holds the MDC divisor, the bus selector and a read-only busy flag. Writing a read or write opcode into the command register starts one serial frame. While the frame runs, the busy flag stays set. When the flag drops, the low half of the command register holds either the 16-bit value the PHY returned or the data that was sent.

MDC is derived from the system clock. One MDC period lasts D clock cycles, where D is the 7-bit divisor, raised to 2 when it is smaller than 2. The low phase lasts ceil(D/2) cycles and the high phase floor(D/2) cycles. MDIO changes at the start of each low phase. Read data is sampled on the clock in which MDC rises. Two management buses hang off the block, and a selector bit picks which one carries the traffic.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy flag is 0, the divisor is 0x1A, the bus selector is 0, the command register reads 0, and both MDC and MDIO enable outputs are low.
- R2: While busy, MDC on the selected bus repeats with a period of D cycles (D = max(divisor,2)): ceil(D/2) cycles low, then floor(D/2) cycles high, starting low in the cycle after the command is accepted.
- R3: A frame is 64 bits, most significant first, one bit per MDC period: 32 ones, then 01, the opcode (01 write, 10 read), the PHY address, the register address, turnaround 10 on writes, then 16 data bits. On a write the master drives all 64 bits.
- R4: On a read the master stops driving MDIO from bit 46 onward, which covers the turnaround and data. It shifts in the selected bus input on each rising-MDC cycle of bits 48..63. After busy falls, bits [15:0] of the command register hold those 16 bits, first received in bit 15.
- R5: The busy flag (setup register bit 8) reads 1 from the cycle after a command is accepted, for exactly 64*D cycles.
- R6: A command write while busy is ignored and leaves the running frame and the stored fields unchanged.
- R7: A command with opcode field [29:28] equal to 00 or 11 is ignored: busy stays 0 and the register contents are kept.
- R8: Only the bus chosen by setup bit 7 (0 or 1) sees MDC and the MDIO enable. The other bus has MDC low and the enable low. Reads sample only the selected bus input.
- R9: A setup register write while busy is ignored. When idle, a write loads the divisor from bits [6:0] and the selector from bit 7.
- R10: When not busy, MDC and both MDIO enables are low.

Command register layout (address 1): opcode [29:28], PHY address [27:23], register address [22:18], data [15:0]. Other bits read 0. Setup register (address 0): divisor [6:0], selector [7], busy [8], other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = setup register, 1 = command register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mdc_o | output | 2 | Management clock, one per bus |
| mdio_o | output | 1 | Serial data driven toward the PHYs |
| mdio_oe | output | 2 | MDIO drive enable, one per bus |
| mdio_i | input | 2 | Serial data from the PHYs, one per bus |

## Verification
The bench targets the odd divisor, where a design that splits the period evenly would shift every rising edge by a cycle and sample read data in the wrong place. It covers divisors 0 and 1, which must act like 2 and would otherwise stall MDC or wrap its counter. Commands and setup writes issued mid-frame check that the divisor and fields hold, since a design that accepted them would restart or corrupt the frame. On the unselected bus the bench drives the inverse of the PHY data, so a read from the wrong bus returns a complemented result. Turnaround release is checked bit by bit, because holding the enable one bit too long would collide with the PHY.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int DIV_W     = 7;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
    localparam int DATA_POS  = TA_POS + 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } mdio_op_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = mdio_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             bit_end_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_state_t;

    clk_state_t q, d;
    logic [DIV_W-1:0] eff, lo_len, hi_len;

    always_comb begin
        eff       = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
        hi_len    = eff >> 1;
        lo_len    = eff - hi_len;
        rise_o    = run_i && !q.mdc && (q.cnt == lo_len - DIV_W'(1));
        bit_end_o = run_i &&  q.mdc && (q.cnt == hi_len - DIV_W'(1));
        d = q;
        if (!run_i) begin
            d = '0;
        end else if (rise_o) begin
            d.mdc = 1'b1;
            d.cnt = '0;
        end else if (bit_end_o) begin
            d.mdc = 1'b0;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc_o = q.mdc;

    // R2
    clk_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
    parameter int PRE_LEN = mdio_pkg::PRE_LEN
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  op_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  reg_i,
    input  logic [15:0] wdata_i,
    input  logic        rise_i,
    input  logic        bit_end_i,
    input  logic        sdi_i,
    output logic        busy_o,
    output logic        sdo_o,
    output logic        sdo_en_o,
    output logic [15:0] data_o
);
    import mdio_pkg::*;

    localparam int FLEN  = PRE_LEN + 32;
    localparam int IDX_W = $clog2(FLEN + 1);
    localparam int TA_AT = PRE_LEN + 14;
    localparam int RD_AT = TA_AT + 2;

    typedef struct packed {
        logic             busy;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [FLEN-1:0]  shf;
        logic [15:0]      data;
    } frame_state_t;

    frame_state_t q, d;
    logic [1:0] ta;
    logic       is_rd;

    always_comb begin
        is_rd = (op_i == OP_READ);
        ta    = is_rd ? 2'b00 : 2'b10;
        d = q;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.rd   = is_rd;
                d.idx  = '0;
                d.shf  = {{PRE_LEN{1'b1}}, 2'b01, op_i, phy_i, reg_i, ta, wdata_i};
                d.data = wdata_i;
            end
        end else begin
            if (rise_i && q.rd && (q.idx >= IDX_W'(RD_AT)))
                d.data = {q.data[14:0], sdi_i};
            if (bit_end_i) begin
                d.shf = q.shf << 1;
                d.idx = q.idx + IDX_W'(1);
                if (q.idx == IDX_W'(FLEN - 1))
                    d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = q.busy;
    assign sdo_o    = q.shf[FLEN-1];
    assign sdo_en_o = q.busy && (!q.rd || (q.idx < IDX_W'(TA_AT)));
    assign data_o   = q.data;

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(bit_end_i));
    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.rd && q.idx >= IDX_W'(TA_AT)) |-> !sdo_en_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int           DIV_W     = mdio_pkg::DIV_W,
    parameter int           PRE_LEN   = mdio_pkg::PRE_LEN,
    parameter int           BUS_N     = 2,
    parameter logic [6:0]   RESET_DIV = 7'h1A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [1:0]  mdc_o,
    output logic        mdio_o,
    output logic [1:0]  mdio_oe,
    input  logic [1:0]  mdio_i
);
    import mdio_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             sel;
        logic [1:0]       op;
        logic [4:0]       phy;
        logic [4:0]       rga;
    } cfg_state_t;

    cfg_state_t q, d;
    logic       busy, start, op_ok;
    logic       mdc, rise, bit_end, sdo_en, sdi;
    logic [15:0] data;

    always_comb begin
        op_ok = (reg_wdata[29:28] == OP_WRITE) || (reg_wdata[29:28] == OP_READ);
        start = reg_we && reg_addr && !busy && op_ok;
        d = q;
        if (reg_we && !reg_addr && !busy) begin
            d.div = reg_wdata[DIV_W-1:0];
            d.sel = reg_wdata[7];
        end
        if (start) begin
            d.op  = reg_wdata[29:28];
            d.phy = reg_wdata[27:23];
            d.rga = reg_wdata[22:18];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= RESET_DIV[DIV_W-1:0];
        end else begin
            q <= d;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .div_i     (q.div),
        .mdc_o     (mdc),
        .rise_o    (rise),
        .bit_end_o (bit_end)
    );

    mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .op_i      (reg_wdata[29:28]),
        .phy_i     (reg_wdata[27:23]),
        .reg_i     (reg_wdata[22:18]),
        .wdata_i   (reg_wdata[15:0]),
        .rise_i    (rise),
        .bit_end_i (bit_end),
        .sdi_i     (sdi),
        .busy_o    (busy),
        .sdo_o     (mdio_o),
        .sdo_en_o  (sdo_en),
        .data_o    (data)
    );

    assign sdi = mdio_i[q.sel];

    for (genvar b = 0; b < BUS_N; b++) begin : g_bus
        assign mdc_o[b]   = (q.sel == 1'(b)) && mdc;
        assign mdio_oe[b] = (q.sel == 1'(b)) && sdo_en;
    end

    always_comb begin
        if (reg_addr)
            reg_rdata = {2'b00, q.op, q.phy, q.rga, 2'b00, data};
        else
            reg_rdata = {{(32-DIV_W-2){1'b0}}, busy, q.sel, q.div};
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdc_o == 2'b00 && mdio_oe == 2'b00));
    // R8
    one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdc_o) && $onehot0(mdio_oe));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && !reg_addr) |=> $stable(q.div) && $stable(q.sel));
    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr) |=> $stable(q.op) && $stable(q.phy) && $stable(q.rga));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  mdc_o;
    logic        mdio_o;
    logic [1:0]  mdio_oe;
    logic [1:0]  mdio_i;

    always #4 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    bit          m_busy = 0;
    int          m_k = 0;
    int          m_D = 26;
    int          m_L = 13;
    logic [63:0] m_frame = '0;
    bit          m_read = 0;
    logic [6:0]  m_div = 7'h1A;
    logic        m_sel = 1'b0;
    logic [1:0]  m_op = '0;
    logic [4:0]  m_phy = '0;
    logic [4:0]  m_reg = '0;
    logic [15:0] m_data = '0;
    logic [15:0] m_resp = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        int  bi;
        logic emdc, eoe;
        bi   = m_k / m_D;
        emdc = m_busy && ((m_k % m_D) >= m_L);
        eoe  = m_busy && (!m_read || bi < 46);
        chk(mdc_o[m_sel] === emdc, "R2 mdc", 32'(mdc_o), 32'(emdc));
        chk(mdc_o[!m_sel] === 1'b0 && mdio_oe[!m_sel] === 1'b0, "R8 unselected bus",
            {mdc_o, mdio_oe}, 32'h0);
        chk(mdio_oe[m_sel] === eoe, "R4 mdio_oe", 32'(mdio_oe), 32'(eoe));
        if (eoe)
            chk(mdio_o === m_frame[63-bi], "R3 mdio_o", 32'(mdio_o), 32'(m_frame[63-bi]));
        if (!m_busy)
            chk(mdc_o === 2'b00 && mdio_oe === 2'b00, "R10 idle", {mdc_o, mdio_oe}, 32'h0);
        if (reg_addr == 1'b0)
            chk(reg_rdata === {23'b0, m_busy, m_sel, m_div}, "R5 setup/busy readback",
                reg_rdata, {23'b0, m_busy, m_sel, m_div});
        else if (!m_busy)
            chk(reg_rdata === {2'b00, m_op, m_phy, m_reg, 2'b00, m_data}, "R4 command readback",
                reg_rdata, {2'b00, m_op, m_phy, m_reg, 2'b00, m_data});
    endtask

    task automatic step(input bit we, input bit addr, input logic [31:0] wd);
        int   bi;
        logic pb;
        @(negedge clk);
        compare();
        bi = m_k / m_D;
        pb = (m_busy && m_read && bi >= 48) ? m_resp[15-(bi-48)] : 1'b1;
        mdio_i[m_sel]  = pb;
        mdio_i[!m_sel] = ~pb;
        reg_we    = we;
        reg_addr  = addr;
        reg_wdata = wd;
        if (m_busy) begin
            m_k++;
            if (m_k == 64 * m_D) begin
                m_busy = 0;
                m_k    = 0;
            end
        end else if (we) begin
            if (!addr) begin
                m_div = wd[6:0];
                m_sel = wd[7];
                m_D   = (wd[6:0] < 2) ? 2 : int'(wd[6:0]);
                m_L   = m_D - m_D / 2;
            end else if (wd[29:28] == 2'b01 || wd[29:28] == 2'b10) begin
                m_op    = wd[29:28];
                m_phy   = wd[27:23];
                m_reg   = wd[22:18];
                m_read  = (wd[29:28] == 2'b10);
                m_frame = {32'hFFFF_FFFF, 2'b01, wd[29:28], wd[27:23], wd[22:18],
                           m_read ? 2'b00 : 2'b10, wd[15:0]};
                m_data  = m_read ? m_resp : wd[15:0];
                m_busy  = 1;
                m_k     = 0;
            end
        end
    endtask

    function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] dat);
        return {2'b00, op, phy, rg, 2'b00, dat};
    endfunction

    task automatic run_frame(input logic [31:0] c);
        step(1, 1, c);
        while (m_busy) step(0, 1, 32'h0);
        step(0, 1, 32'h0);
        step(0, 0, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = '0; mdio_i = 2'b11;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(reg_rdata === {23'b0, 1'b0, 1'b0, 7'h1A}, "R1 setup reset", reg_rdata, 32'h1A);
        chk(mdc_o === 2'b00 && mdio_oe === 2'b00, "R1 pins reset", {mdc_o, mdio_oe}, 32'h0);
        reg_addr = 1'b1;
        #1;
        chk(reg_rdata === 32'h0, "R1 command reset", reg_rdata, 32'h0);
        reg_addr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 32'h0);

        // write on internal bus, even divisor (R3)
        step(1, 0, 32'h0000_0004);
        run_frame(cmd(2'b01, 5'd5, 5'd3, 16'hA53C));

        // read on external bus, odd divisor (R4, R8)
        m_resp = 16'h1234;
        step(1, 0, 32'h0000_0083);
        run_frame(cmd(2'b10, 5'd17, 5'd30, 16'h0000));

        // divisor 0 acts as 2, read on bus 0 (R2)
        m_resp = 16'hBEEF;
        step(1, 0, 32'h0000_0000);
        run_frame(cmd(2'b10, 5'd31, 5'd1, 16'hFFFF));

        // divisor 1 acts as 2, write with all-ones data (R2, R3)
        step(1, 0, 32'h0000_0001);
        run_frame(cmd(2'b01, 5'd0, 5'd31, 16'hFFFF));

        // mid-frame writes ignored (R6, R9)
        step(1, 0, 32'h0000_0005);
        m_resp = 16'h8001;
        step(1, 1, cmd(2'b10, 5'd9, 5'd12, 16'h0));
        repeat (20) step(0, 1, 32'h0);
        step(1, 1, cmd(2'b01, 5'd2, 5'd4, 16'h5555));
        step(0, 0, 32'h0);
        step(1, 0, 32'h0000_0082);
        while (m_busy) step(0, 1, 32'h0);
        step(0, 1, 32'h0);
        #1;
        chk(reg_rdata[29:18] === {2'b10, 5'd9, 5'd12}, "R6 fields kept", 32'(reg_rdata[29:18]),
            32'({2'b10, 5'd9, 5'd12}));
        chk(reg_rdata[15:0] === 16'h8001, "R6 result kept", 32'(reg_rdata[15:0]), 32'h8001);
        step(0, 0, 32'h0);
        #1;
        chk(reg_rdata[7:0] === 8'h05, "R9 setup kept", 32'(reg_rdata[7:0]), 32'h05);

        // reserved opcodes ignored (R7)
        step(1, 1, cmd(2'b00, 5'd7, 5'd7, 16'h7777));
        step(1, 1, cmd(2'b11, 5'd6, 5'd6, 16'h6666));
        step(0, 0, 32'h0);
        #1;
        chk(reg_rdata[8] === 1'b0, "R7 busy stays low", 32'(reg_rdata[8]), 32'h0);
        step(0, 1, 32'h0);
        #1;
        chk(reg_rdata === {2'b00, 2'b10, 5'd9, 5'd12, 2'b00, 16'h8001}, "R7 register kept",
            reg_rdata, {2'b00, 2'b10, 5'd9, 5'd12, 2'b00, 16'h8001});
        repeat (3) step(0, 0, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule